// File: doc/BRIEF.md
# Chance-Weighted Looping Shift Register

This block is an eight-stage serial register that advances once for every rising edge of a gate clock called the bus clock. On each advance, one new bit enters at the head of the register. That bit is chosen from three sources: the external data bit, the bit recirculated from a selectable loop point, or the exclusive-OR of the two. An internal eight-bit pseudo-random sequence makes the choice, weighted by an eight-bit chance value. At the top of the chance range the stored pattern locks and repeats without end. At the bottom of the range, fresh data is always mixed with the loop-point bit. A manual write control can force a high or a low into the register, and this force wins over the other sources.

The direction of travel can be reversed by a rising edge on a button input or on a trigger input. When it is reversed, new bits enter at the far end and the loop-point tap mirrors to match. Besides the eight stage bits, the block drives three outputs. The first is a gate: the first stage ANDed with the live bus-clock level. The other two are a three-bit word and an eight-bit word, each made of register bits taken in reversed order. These words feed downstream converters. All inputs are sampled on the system clock `clk` and must be synchronous to it. Edges on the bus clock, the button and the trigger are found by comparing each input with its value one cycle earlier.

Top module: `chance_loop_shreg`

## Requirements
- R1: The register changes only on a cycle where `bus_clk` is 1 and was 0 on the previous system clock. Each such rise shifts it by exactly one place, and holding `bus_clk` high causes no further shifts.
- R2: In forward direction (the state after reset), the new bit enters `stages[0]` and each `stages[i]` takes the old `stages[i-1]`.
- R3: A rising edge on `dir_button` or `dir_trig` toggles the direction once, even when both rise in the same cycle. A shift in that same cycle still uses the old direction. In reverse, the new bit enters `stages[7]` and each `stages[i]` takes the old `stages[i+1]`.
- R4: The loop-point bit is `stages[len_m1]` in forward direction and `stages[7-len_m1]` in reverse, so the loop length is `len_m1+1`, from 1 to 8.
- R5: The pseudo-random value is an 8-bit shift sequence that starts at 8'h01 after reset. On each shift it advances once, after it has been used, to `{r[6:0], r[7]^r[5]^r[4]^r[3]}`.
- R6: When `chance >= 128`, the new bit is the loop-point bit if the random value is at most `{chance[6:0],1'b1}`, and the data bit otherwise. At `chance = 255` the pattern always recirculates, so with length 8 it returns unchanged after 8 shifts.
- R7: When `chance < 128`, the new bit is data XOR loop-point bit if the random value exceeds `{chance[6:0],1'b0}`, and the data bit otherwise. At `chance = 0` the XOR is always taken.
- R8: While `wr_force_en` is 1, the new bit equals `wr_force_val` whatever the chance and data.
- R9: `gate_out` equals `stages[0]` AND the present `bus_clk` level.
- R10: `word_wide[i] = stages[7-i]` and `word_narrow[i] = stages[2-i]`.
- R11: While reset is asserted, and for two clocks after it is released, all stages are 0, direction is forward and the random value is 8'h01.
- R12: After the length is shortened with the pattern locked, bits that lay beyond the new loop point are lost: the tail stages fill with copies of the shortened loop.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| bus_clk | input | 1 | Bus-one gate clock level; its rising edge shifts the register |
| data_in | input | 1 | External data bit |
| dir_button | input | 1 | Front button level; a rising edge reverses direction |
| dir_trig | input | 1 | External trigger level; a rising edge reverses direction |
| wr_force_en | input | 1 | Manual write enable, overrides other sources |
| wr_force_val | input | 1 | Level forced in by manual write |
| len_m1 | input | 3 | Loop length minus one |
| chance | input | 8 | Chance weighting value |
| stages | output | 8 | Current register bits |
| gate_out | output | 1 | First stage ANDed with the bus clock level |
| word_narrow | output | 3 | First three stages, bit-reversed |
| word_wide | output | 8 | All stages, bit-reversed |

## Verification
A forced write sequence loads a known pattern, which shows that the write override and the reversed output words are right. A full-length rotation at maximum chance then separates recirculation from data entry, and a run at zero chance separates the XOR path from plain data. The loop length is shortened while the pattern is locked, which exposes a wrong tap index. Button and trigger edges, alone and together, show whether the toggle and the mirrored tap follow the direction. A long stretch with random data, lengths and mid-range chance values checks, on every clock, the weighted choice and the advance of the pseudo-random sequence against the reference model.

// File: rtl/clr_pkg.sv
package clr_pkg;
  typedef enum logic {
    DIR_FWD = 1'b0,
    DIR_REV = 1'b1
  } dir_t;

  typedef enum logic [1:0] {
    SRC_DATA  = 2'd0,
    SRC_LOOP  = 2'd1,
    SRC_XOR   = 2'd2,
    SRC_FORCE = 2'd3
  } src_t;
endpackage

// File: rtl/clr_rst_sync.sv
module clr_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_s_n
);
  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  always_comb begin
    chain_d = {chain_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= chain_d;
  end

  assign rst_s_n = chain_q[STAGES-1];
endmodule

// File: rtl/clr_edge_rise.sv
module clr_edge_rise #(
  parameter int W = 3
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] level,
  output logic [W-1:0] rise
);
  logic [W-1:0] prev_q;
  logic [W-1:0] prev_d;

  always_comb begin
    prev_d = level;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= '0;
    else        prev_q <= prev_d;
  end

  assign rise = level & ~prev_q;
endmodule

// File: rtl/clr_lfsr.sv
module clr_lfsr #(
  parameter int         W    = 8,
  parameter logic [W-1:0] MASK = 8'hB8,
  parameter logic [W-1:0] SEED = 8'h01
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         adv,
  output logic [W-1:0] state
);
  logic [W-1:0] state_q;
  logic [W-1:0] state_d;
  logic         fb;

  always_comb begin
    fb      = ^(state_q & MASK);
    state_d = state_q;
    if (adv) state_d = {state_q[W-2:0], fb};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= SEED;
    else        state_q <= state_d;
  end

  assign state = state_q;
endmodule

// File: rtl/clr_shift_core.sv
module clr_shift_core
  import clr_pkg::*;
#(
  parameter int W  = 8,
  parameter int CW = 8,
  localparam int LW = $clog2(W)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          shift_en,
  input  logic          dir_flip,
  input  logic [LW-1:0] len_m1,
  input  logic [CW-1:0] chance,
  input  logic [CW-1:0] rnd,
  input  logic          data_bit,
  input  logic          force_en,
  input  logic          force_val,
  output logic [W-1:0]  stages,
  output logic          dir_rev
);
  localparam logic [LW-1:0] LAST = LW'(W - 1);

  logic [W-1:0]  stages_q, stages_d;
  dir_t          dir_q, dir_d;
  logic [LW-1:0] tap_idx;
  logic          tap_bit;
  logic [CW-1:0] thr_hi, thr_lo;
  src_t          src;
  logic          new_bit;

  // loop-point selection, mirrored in reverse
  always_comb begin
    if (dir_q == DIR_REV) tap_idx = LAST - len_m1;
    else                  tap_idx = len_m1;
    tap_bit = stages_q[tap_idx];
  end

  // chance-weighted source choice
  always_comb begin
    thr_hi = {chance[CW-2:0], 1'b1};
    thr_lo = {chance[CW-2:0], 1'b0};
    if (force_en)          src = SRC_FORCE;
    else if (chance[CW-1]) src = (rnd <= thr_hi) ? SRC_LOOP : SRC_DATA;
    else                   src = (rnd >  thr_lo) ? SRC_XOR  : SRC_DATA;
  end

  always_comb begin
    unique case (src)
      SRC_FORCE: new_bit = force_val;
      SRC_LOOP:  new_bit = tap_bit;
      SRC_XOR:   new_bit = data_bit ^ tap_bit;
      default:   new_bit = data_bit;
    endcase
  end

  // next state
  always_comb begin
    stages_d = stages_q;
    if (shift_en) begin
      if (dir_q == DIR_REV) stages_d = {new_bit, stages_q[W-1:1]};
      else                  stages_d = {stages_q[W-2:0], new_bit};
    end
    dir_d = dir_q;
    if (dir_flip) dir_d = (dir_q == DIR_REV) ? DIR_FWD : DIR_REV;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stages_q <= '0;
      dir_q    <= DIR_FWD;
    end else begin
      stages_q <= stages_d;
      dir_q    <= dir_d;
    end
  end

  assign stages  = stages_q;
  assign dir_rev = (dir_q == DIR_REV);
endmodule

// File: rtl/chance_loop_shreg.sv
module chance_loop_shreg #(
  parameter int W  = 8,
  parameter int CW = 8,
  parameter int NW = 3,
  localparam int LW = $clog2(W)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          bus_clk,
  input  logic          data_in,
  input  logic          dir_button,
  input  logic          dir_trig,
  input  logic          wr_force_en,
  input  logic          wr_force_val,
  input  logic [LW-1:0] len_m1,
  input  logic [CW-1:0] chance,
  output logic [W-1:0]  stages,
  output logic          gate_out,
  output logic [NW-1:0] word_narrow,
  output logic [W-1:0]  word_wide
);
  logic          rst_s_n;
  logic [2:0]    rises;
  logic          bus_rise;
  logic          dir_flip;
  logic [CW-1:0] rnd;
  logic          dir_rev;

  clr_rst_sync #(.STAGES(2)) u_rst (
    .clk     (clk),
    .rst_n   (rst_n),
    .rst_s_n (rst_s_n)
  );

  clr_edge_rise #(.W(3)) u_edge (
    .clk   (clk),
    .rst_n (rst_s_n),
    .level ({dir_trig, dir_button, bus_clk}),
    .rise  (rises)
  );

  assign bus_rise = rises[0];
  assign dir_flip = rises[1] | rises[2];

  clr_lfsr #(.W(CW), .MASK(CW'(8'hB8)), .SEED(CW'(1))) u_lfsr (
    .clk   (clk),
    .rst_n (rst_s_n),
    .adv   (bus_rise),
    .state (rnd)
  );

  clr_shift_core #(.W(W), .CW(CW)) u_core (
    .clk       (clk),
    .rst_n     (rst_s_n),
    .shift_en  (bus_rise),
    .dir_flip  (dir_flip),
    .len_m1    (len_m1),
    .chance    (chance),
    .rnd       (rnd),
    .data_bit  (data_in),
    .force_en  (wr_force_en),
    .force_val (wr_force_val),
    .stages    (stages),
    .dir_rev   (dir_rev)
  );

  assign gate_out = stages[0] & bus_clk;

  for (genvar i = 0; i < W; i++) begin : g_wide
    assign word_wide[i] = stages[W-1-i];
  end
  for (genvar i = 0; i < NW; i++) begin : g_narrow
    assign word_narrow[i] = stages[NW-1-i];
  end
endmodule

// File: rtl/clr_checker.sv
module clr_checker #(
  parameter int W  = 8,
  parameter int CW = 8,
  localparam int LW = $clog2(W)
) (
  input logic          clk,
  input logic          rst_s_n,
  input logic          bus_rise,
  input logic          dir_rev,
  input logic [W-1:0]  stages,
  input logic [CW-1:0] chance,
  input logic [LW-1:0] len_m1,
  input logic          force_en,
  input logic          force_val,
  input logic          data_in,
  input logic [CW-1:0] rnd
);
  a_r1_hold_between_rises: assert property (@(posedge clk) disable iff (!rst_s_n)
    !bus_rise |=> $stable(stages));

  a_r2_forward_move: assert property (@(posedge clk) disable iff (!rst_s_n)
    (bus_rise && !dir_rev) |=> (stages[W-1:1] == $past(stages[W-2:0])));

  a_r3_reverse_move: assert property (@(posedge clk) disable iff (!rst_s_n)
    (bus_rise && dir_rev) |=> (stages[W-2:0] == $past(stages[W-1:1])));

  a_r5_seq_nonzero: assert property (@(posedge clk) disable iff (!rst_s_n)
    rnd != '0);

  a_r6_locked_recirc: assert property (@(posedge clk) disable iff (!rst_s_n)
    (bus_rise && !dir_rev && !force_en && chance == '1)
      |=> (stages[0] == $past(stages[len_m1])));

  a_r7_min_xor: assert property (@(posedge clk) disable iff (!rst_s_n)
    (bus_rise && !dir_rev && !force_en && chance == '0)
      |=> (stages[0] == ($past(data_in) ^ $past(stages[len_m1]))));

  a_r8_force_wins: assert property (@(posedge clk) disable iff (!rst_s_n)
    (bus_rise && !dir_rev && force_en) |=> (stages[0] == $past(force_val)));
endmodule

bind chance_loop_shreg clr_checker #(.W(W), .CW(CW)) u_chk (
  .clk       (clk),
  .rst_s_n   (rst_s_n),
  .bus_rise  (bus_rise),
  .dir_rev   (dir_rev),
  .stages    (stages),
  .chance    (chance),
  .len_m1    (len_m1),
  .force_en  (wr_force_en),
  .force_val (wr_force_val),
  .data_in   (data_in),
  .rnd       (rnd)
);

// File: tb/sim_chance_loop_shreg.sv
`timescale 1ns/100ps
module sim_chance_loop_shreg;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic bus_clk = 1'b0, data_in = 1'b0, dir_button = 1'b0, dir_trig = 1'b0;
  logic wr_force_en = 1'b0, wr_force_val = 1'b0;
  logic [2:0] len_m1 = 3'd7;
  logic [7:0] chance = 8'd255;
  logic [7:0] stages;
  logic gate_out;
  logic [2:0] word_narrow;
  logic [7:0] word_wide;

  int n_cmp = 0, n_bad = 0, cyc = 0;
  bit started = 0, done = 0;
  string cur_req = "R11";

  always #2.5 clk = ~clk;

  chance_loop_shreg u0 (
    .clk(clk), .rst_n(rst_n), .bus_clk(bus_clk), .data_in(data_in),
    .dir_button(dir_button), .dir_trig(dir_trig),
    .wr_force_en(wr_force_en), .wr_force_val(wr_force_val),
    .len_m1(len_m1), .chance(chance), .stages(stages), .gate_out(gate_out),
    .word_narrow(word_narrow), .word_wide(word_wide));

  // behavioural reference
  bit mreg [8];
  bit mdir;
  int mseq, rcnt;
  bit pbus, pbtn, ptrig;

  always @(posedge clk) begin
    bit rise, flip, tap, nb;
    int thr;
    if (!rst_n || rcnt < 2) begin
      if (!rst_n) rcnt = 0; else rcnt++;
      foreach (mreg[i]) mreg[i] = 0;
      mdir = 0; mseq = 1; pbus = 0; pbtn = 0; ptrig = 0;
      started = 1;
    end else begin
      rise = bus_clk && !pbus;
      flip = (dir_button && !pbtn) || (dir_trig && !ptrig);
      if (rise) begin
        tap = mdir ? mreg[7 - int'(len_m1)] : mreg[int'(len_m1)];
        if (wr_force_en) nb = wr_force_val;
        else if (chance >= 128) begin
          thr = (int'(chance) - 128) * 2 + 1;
          nb = (mseq <= thr) ? tap : data_in;
        end else begin
          thr = int'(chance) * 2;
          nb = (mseq > thr) ? (data_in ^ tap) : data_in;
        end
        if (mdir) begin
          for (int i = 0; i < 7; i++) mreg[i] = mreg[i+1];
          mreg[7] = nb;
        end else begin
          for (int i = 7; i > 0; i--) mreg[i] = mreg[i-1];
          mreg[0] = nb;
        end
        mseq = ((mseq << 1) & 255) |
               (((mseq >> 7) ^ (mseq >> 5) ^ (mseq >> 4) ^ (mseq >> 3)) & 1);
      end
      if (flip) mdir = !mdir;
      pbus = bus_clk; pbtn = dir_button; ptrig = dir_trig;
    end
  end

  function automatic logic [7:0] mvec();
    logic [7:0] v;
    for (int i = 0; i < 8; i++) v[i] = mreg[i];
    return v;
  endfunction

  task automatic chk(string req, int act, int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h at cycle %0d", req, act, exp, cyc);
    end
  endtask

  // every-clock comparison, away from the active edge
  always @(posedge clk) begin
    #1;
    if (started && !done) begin
      logic [7:0] e;
      e = mvec();
      chk({cur_req, " stages"}, stages, e);
      chk("R9 gate", gate_out, e[0] & bus_clk);
      chk("R10 wide", word_wide, {e[0],e[1],e[2],e[3],e[4],e[5],e[6],e[7]});
      chk("R10 narrow", word_narrow, {e[0],e[1],e[2]});
    end
  end

  task automatic finish_run();
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000 && !done) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_run();
    end
  end

  task automatic wait_n(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic bus_pulse(int hi);
    @(negedge clk); bus_clk = 1'b1;
    wait_n(hi);
    bus_clk = 1'b0;
    wait_n(2);
  endtask

  task automatic force_bit(bit v);
    @(negedge clk); wr_force_en = 1'b1; wr_force_val = v;
    bus_pulse(2);
    wr_force_en = 1'b0;
  endtask

  initial begin
    logic [7:0] snap;
    wait_n(4);
    rst_n = 1'b1;
    wait_n(4);
    chk("R11 reset stages", stages, 0);
    chk("R11 reset wide", word_wide, 0);

    // R8 load by forced writes; R2 forward entry
    cur_req = "R8";
    force_bit(1); force_bit(0); force_bit(1); force_bit(1);
    chk("R8 forced pattern", stages, 8'h0B);
    chk("R10 wide reversed", word_wide, 8'hD0);
    chk("R10 narrow reversed", word_narrow, 3'b110);
    @(negedge clk); bus_clk = 1'b1;
    #0.5 chk("R9 gate follows bus", gate_out, 1);

    // R1: bus held high, one shift only
    cur_req = "R1";
    wait_n(1); snap = stages;
    wait_n(6);
    chk("R1 no extra shift", stages, snap);
    bus_clk = 1'b0; wait_n(2);
    chk("R9 gate low with bus", gate_out, 0);

    // R6 lock at full chance, length 8
    cur_req = "R6";
    chance = 8'd255; len_m1 = 3'd7;
    snap = stages;
    for (int i = 0; i < 8; i++) begin
      data_in = i[0];
      bus_pulse(1);
    end
    chk("R6 locked pattern returns", stages, snap);

    // R12 shortened length loses tail bits
    cur_req = "R12";
    len_m1 = 3'd2;
    for (int i = 0; i < 10; i++) bus_pulse(1);
    chk("R12 tail copies loop", stages[7:3], {stages[4:3], stages[2:0]});

    // R7 XOR at zero chance
    cur_req = "R7";
    chance = 8'd0; len_m1 = 3'd4;
    for (int i = 0; i < 12; i++) begin
      data_in = (i % 3) == 0;
      bus_pulse(1);
    end

    // R3 direction toggles, R4 mirrored tap
    cur_req = "R3";
    @(negedge clk); dir_button = 1'b1; wait_n(1); dir_button = 1'b0;
    chance = 8'd255; len_m1 = 3'd2;
    for (int i = 0; i < 6; i++) bus_pulse(1);
    cur_req = "R4";
    force_bit(1); force_bit(0);
    chk("R4 reverse entry", stages[7:6], 2'b01);
    for (int i = 0; i < 9; i++) bus_pulse(1);
    @(negedge clk); dir_button = 1'b1; dir_trig = 1'b1;
    wait_n(1); dir_button = 1'b0; dir_trig = 1'b0;
    cur_req = "R3";
    force_bit(1);
    chk("R3 both edges toggle once", stages[0], 1);
    @(negedge clk); dir_trig = 1'b1; bus_clk = 1'b1;
    wait_n(1); dir_trig = 1'b0;
    wait_n(1); bus_clk = 1'b0; wait_n(2);

    // R5 weighted choice over the pseudo-random sequence
    cur_req = "R5";
    for (int i = 0; i < 400; i++) begin
      @(negedge clk);
      data_in = $urandom_range(0, 1);
      if (i % 40 == 0) chance = 8'($urandom_range(0, 255));
      if (i % 25 == 0) len_m1 = 3'($urandom_range(0, 7));
      if (i % 57 == 0) dir_trig = 1'b1;
      wait_n(1); dir_trig = 1'b0;
      bus_pulse($urandom_range(1, 3));
    end
    wait_n(3);
    finish_run();
  end
endmodule